// File: doc/BRIEF.md
# ATA 8-bit PIO Sector Sequencer

This block is the host side of an ATA/IDE-style disk link that runs over an 8-bit register bus using programmed I/O. It comes out of reset by pulsing the device reset line. It then waits a programmable start-up interval. Next it switches the device to 8-bit transfers with a Set Features command. From then on it serves single-sector LBA read and write requests. For each request it polls the status register, loads the task-file registers and issues the command. It waits for the device to ask for data, then moves one 512-byte sector through the data register.

The user side takes a request as a valid/ready pair. The request carries a direction, a 28-bit LBA, a sector-count byte and a master/slave select. Write bytes enter on a valid/ready stream, and read bytes leave on a valid-only stream. A one-cycle done pulse ends every sequence, including the start-up sequence. The done pulse carries a device-error flag with the device's error byte, or a timeout flag. The device side has a split 8-bit data bus with an output-enable, which the chip-level pad ring joins into one tristate bus.

Top module: `ata_sector_seq`

## Requirements
- R1: While `rst_n` is low and for RESET_CYC cycles after it rises, `dev_rst_n` is low. No bus access (`dev_cs_n` low) starts before RESET_CYC+STARTUP_CYC cycles after reset release.
- R2: The start-up sequence polls status until bit 7 reads 0. It then writes, in this order, offset 1 = 0x01, offset 6 = {3'b111, INIT_SLAVE, 4'h0} and offset 7 = 0xEF. It then pulses `done` with no error flag, and `req_ready` rises.
- R3: For each request, the task file is written in this fixed order: offset 2 = count, offset 3 = LBA[7:0], offset 4 = LBA[15:8], offset 5 = LBA[23:16], offset 6 = {3'b111, slave, LBA[27:24]}, and offset 7 = command. The command is 0x20 for a read and 0x30 for a write.
- R4: Before the first task-file write, status (a read of offset 7) is polled until a read returns bit 7 (busy) = 0. No write happens while busy reads 1.
- R5: After the command write, status is polled until a read shows bit 7 = 0 and bit 3 (data request) = 1. No data-register access happens before that read.
- R6: If a poll sees bit 7 = 0 with bit 0 (error) = 1, offset 1 is read once and the sequence ends. `done` pulses with `err_dev` = 1 and `err_code` = the byte read, and no further task-file or data access takes place.
- R7: A poll that is still unresolved after POLL_TIMEOUT cycles ends the sequence. `done` pulses with `err_tmo` = 1 and `err_dev` = 0.
- R8: A read request makes exactly 512 reads of offset 0. Each byte appears on `rd_data` with a one-cycle `rd_valid`, in bus order.
- R9: A write request makes exactly 512 writes of offset 0. Their data are the bytes accepted by `wr_valid && wr_ready`, in order.
- R10: Every access holds `dev_cs_n` low with a stable address. The strobe is preceded by SETUP_CYC cycles, lasts STROBE_CYC cycles and is followed by HOLD_CYC cycles. Read and write strobes are never low together. `dev_oe` is high only during write accesses. `dev_cs_n` returns high between accesses.
- R11: `done` lasts exactly one cycle. `req_ready` is high only while idle and drops the cycle after a request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and taking a request |
| req_write | input | 1 | 1 = write sector, 0 = read sector |
| req_lba | input | 28 | Logical block address |
| req_count | input | 8 | Value for the sector-count register |
| req_slave | input | 1 | Select the slave device |
| wr_data | input | 8 | Write byte |
| wr_valid | input | 1 | Write byte present |
| wr_ready | output | 1 | Write byte taken this cycle when valid |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Read byte strobe |
| done | output | 1 | End-of-sequence pulse |
| err_dev | output | 1 | Device reported an error |
| err_tmo | output | 1 | Poll timed out |
| err_code | output | 8 | Device error register value |
| dev_addr | output | 3 | Task-file register offset |
| dev_cs_n | output | 1 | Chip select, active low |
| dev_rd_n | output | 1 | Read strobe, active low |
| dev_wr_n | output | 1 | Write strobe, active low |
| dev_dout | output | 8 | Bus data toward the device |
| dev_oe | output | 1 | Drive `dev_dout` onto the bus |
| dev_din | input | 8 | Bus data from the device |
| dev_rst_n | output | 1 | Device reset, active low |

## Verification
The bench uses RESET_CYC = 4 and STARTUP_CYC = 20, so the start-up sequence finishes within a few dozen cycles instead of half a second. Setup, strobe and hold are set to the unequal values 2, 3 and 1, so any swapped or miscounted phase shows up in the per-access timing measurement. POLL_TIMEOUT = 300 lets a permanently busy device reach the timeout path quickly. The device model's programmable busy counts and error injection drive both poll stages and both error exits.

// File: rtl/ata_seq_pkg.sv
// Shared types and constants for the ATA 8-bit PIO sector sequencer.
// Assumes the standard task-file layout at offsets 0..7.
package ata_seq_pkg;

    localparam logic [2:0] OFS_DATA  = 3'd0;
    localparam logic [2:0] OFS_ERR   = 3'd1;   // read side
    localparam logic [2:0] OFS_FEAT  = 3'd1;   // write side
    localparam logic [2:0] OFS_CNT   = 3'd2;
    localparam logic [2:0] OFS_LBA0  = 3'd3;
    localparam logic [2:0] OFS_LBA1  = 3'd4;
    localparam logic [2:0] OFS_LBA2  = 3'd5;
    localparam logic [2:0] OFS_DRVHD = 3'd6;
    localparam logic [2:0] OFS_STAT  = 3'd7;   // read side
    localparam logic [2:0] OFS_CMD   = 3'd7;   // write side

    localparam logic [7:0] OP_READ1  = 8'h20;
    localparam logic [7:0] OP_WRITE1 = 8'h30;
    localparam logic [7:0] OP_SETFT  = 8'hEF;
    localparam logic [7:0] FT_BYTE   = 8'h01;

    localparam int BIT_BSY = 7;
    localparam int BIT_DRQ = 3;
    localparam int BIT_ERR = 0;

    typedef enum logic [1:0] {A_IDLE, A_SETUP, A_STROBE, A_HOLD} acc_ph_t;

    typedef enum logic [3:0] {
        Q_RST, Q_WAIT, Q_IDLE, Q_POLL, Q_POLL_W, Q_ERR_RD, Q_ERR_W,
        Q_TF, Q_TF_W, Q_DATA, Q_DATA_W, Q_FIN
    } seq_st_t;

endpackage

// File: rtl/ata_pio_access.sv
// Single register access engine. On start it holds chip select low with a
// fixed address, waits SETUP_CYC cycles, pulses one strobe for STROBE_CYC
// cycles, waits HOLD_CYC cycles, then releases chip select and pulses ack.
// Assumes every cycle count is at least 1 and start arrives only while idle.
module ata_pio_access
    import ata_seq_pkg::*;
#(
    parameter int SETUP_CYC  = 2,
    parameter int STROBE_CYC = 3,
    parameter int HOLD_CYC   = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       wr,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic       ack,
    output logic [7:0] rdata,
    output logic [2:0] dev_addr,
    output logic       dev_cs_n,
    output logic       dev_rd_n,
    output logic       dev_wr_n,
    output logic [7:0] dev_dout,
    output logic       dev_oe,
    input  logic [7:0] dev_din
);
    localparam int CW = $clog2(SETUP_CYC + STROBE_CYC + HOLD_CYC + 1);

    acc_ph_t         ph;
    logic [CW-1:0]   cnt;
    logic            wr_q;
    logic [2:0]      addr_q;
    logic [7:0]      wdata_q;
    logic [7:0]      rdata_q;
    logic            ack_q;

    // Phase sequencing, request capture and read-data sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph      <= A_IDLE;
            cnt     <= '0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            ack_q   <= 1'b0;
        end else begin
            ack_q <= 1'b0;
            case (ph)
                A_IDLE: if (start) begin
                    ph      <= A_SETUP;
                    cnt     <= '0;
                    wr_q    <= wr;
                    addr_q  <= addr;
                    wdata_q <= wdata;
                end
                A_SETUP: if (cnt == CW'(SETUP_CYC - 1)) begin
                    ph  <= A_STROBE;
                    cnt <= '0;
                end else cnt <= cnt + 1'b1;
                A_STROBE: if (cnt == CW'(STROBE_CYC - 1)) begin
                    rdata_q <= dev_din;
                    ph      <= A_HOLD;
                    cnt     <= '0;
                end else cnt <= cnt + 1'b1;
                default: if (cnt == CW'(HOLD_CYC - 1)) begin
                    ph    <= A_IDLE;
                    ack_q <= 1'b1;
                end else cnt <= cnt + 1'b1;
            endcase
        end
    end

    // Bus pins follow the phase register.
    always_comb begin
        dev_cs_n = (ph == A_IDLE);
        dev_rd_n = !((ph == A_STROBE) && !wr_q);
        dev_wr_n = !((ph == A_STROBE) && wr_q);
        dev_oe   = (ph != A_IDLE) && wr_q;
        dev_addr = addr_q;
        dev_dout = wdata_q;
        ack      = ack_q;
        rdata    = rdata_q;
    end

    // R10
    strobes_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rd_n || dev_wr_n);
    // R10
    strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_rd_n || !dev_wr_n) |-> !dev_cs_n);
    // R10
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_cs_n && $past(!dev_cs_n)) |-> $stable(dev_addr));
    // R10
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> dev_cs_n);

endmodule

// File: rtl/ata_tf_encode.sv
// Task-file write list. For step idx it gives the register offset and byte
// to write, and flags the last step. The start-up list selects 8-bit mode;
// the command list loads count, LBA, drive/head and then the command.
// Assumes idx never passes the flagged last step.
module ata_tf_encode
    import ata_seq_pkg::*;
#(
    parameter bit INIT_SLAVE = 1'b0
) (
    input  logic        init_mode,
    input  logic [2:0]  idx,
    input  logic        is_write,
    input  logic [27:0] lba,
    input  logic [7:0]  count,
    input  logic        slave,
    output logic [2:0]  addr,
    output logic [7:0]  data,
    output logic        last
);
    // Select the step's register and value.
    always_comb begin
        addr = OFS_CMD;
        data = 8'h00;
        last = 1'b0;
        if (init_mode) begin
            case (idx)
                3'd0:    begin addr = OFS_FEAT;  data = FT_BYTE; end
                3'd1:    begin addr = OFS_DRVHD; data = {3'b111, INIT_SLAVE, 4'h0}; end
                default: begin addr = OFS_CMD;   data = OP_SETFT; last = 1'b1; end
            endcase
        end else begin
            case (idx)
                3'd0:    begin addr = OFS_CNT;   data = count; end
                3'd1:    begin addr = OFS_LBA0;  data = lba[7:0]; end
                3'd2:    begin addr = OFS_LBA1;  data = lba[15:8]; end
                3'd3:    begin addr = OFS_LBA2;  data = lba[23:16]; end
                3'd4:    begin addr = OFS_DRVHD; data = {3'b111, slave, lba[27:24]}; end
                default: begin
                    addr = OFS_CMD;
                    data = is_write ? OP_WRITE1 : OP_READ1;
                    last = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/ata_sector_seq.sv
// ATA 8-bit PIO sector sequencer. After reset it resets the device, waits for
// it to start, and selects 8-bit transfers. It then serves single-sector LBA
// read/write requests: busy poll, task-file load, data-request poll and a
// 512-byte data phase. Device errors and poll timeouts end a sequence early.
// Assumes all cycle-count parameters are at least 1.
module ata_sector_seq
    import ata_seq_pkg::*;
#(
    parameter int SETUP_CYC    = 2,
    parameter int STROBE_CYC   = 3,
    parameter int HOLD_CYC     = 1,
    parameter int RESET_CYC    = 50,
    parameter int STARTUP_CYC  = 25_000_000,
    parameter int POLL_TIMEOUT = 50_000_000,
    parameter int SECTOR_BYTES = 512,
    parameter bit INIT_SLAVE   = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [27:0] req_lba,
    input  logic [7:0]  req_count,
    input  logic        req_slave,
    input  logic [7:0]  wr_data,
    input  logic        wr_valid,
    output logic        wr_ready,
    output logic [7:0]  rd_data,
    output logic        rd_valid,
    output logic        done,
    output logic        err_dev,
    output logic        err_tmo,
    output logic [7:0]  err_code,
    output logic [2:0]  dev_addr,
    output logic        dev_cs_n,
    output logic        dev_rd_n,
    output logic        dev_wr_n,
    output logic [7:0]  dev_dout,
    output logic        dev_oe,
    input  logic [7:0]  dev_din,
    output logic        dev_rst_n
);
    localparam int WW = $clog2(RESET_CYC + STARTUP_CYC + 1);
    localparam int TW = $clog2(POLL_TIMEOUT + SETUP_CYC + STROBE_CYC + HOLD_CYC + 4) + 1;
    localparam int BW = $clog2(SECTOR_BYTES);

    seq_st_t         st;
    logic [WW-1:0]   wcnt;
    logic [TW-1:0]   tmo_cnt;
    logic [2:0]      idx;
    logic [BW-1:0]   bcnt;
    logic            in_init, drq_stage;
    logic            cur_write, cur_slave;
    logic [27:0]     cur_lba;
    logic [7:0]      cur_count;
    logic            err_dev_q, err_tmo_q;
    logic [7:0]      err_code_q;

    logic            acc_start, acc_wr, acc_ack;
    logic [2:0]      acc_addr;
    logic [7:0]      acc_wdata, acc_rdata;
    logic [2:0]      tf_addr;
    logic [7:0]      tf_data;
    logic            tf_last, tmo_hit;

    assign tmo_hit = (tmo_cnt >= TW'(POLL_TIMEOUT));

    ata_tf_encode #(.INIT_SLAVE(INIT_SLAVE)) tf_i (
        .init_mode(in_init), .idx(idx), .is_write(cur_write), .lba(cur_lba),
        .count(cur_count), .slave(cur_slave),
        .addr(tf_addr), .data(tf_data), .last(tf_last)
    );

    ata_pio_access #(
        .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC)
    ) acc_i (
        .clk(clk), .rst_n(rst_n), .start(acc_start), .wr(acc_wr),
        .addr(acc_addr), .wdata(acc_wdata), .ack(acc_ack), .rdata(acc_rdata),
        .dev_addr(dev_addr), .dev_cs_n(dev_cs_n), .dev_rd_n(dev_rd_n),
        .dev_wr_n(dev_wr_n), .dev_dout(dev_dout), .dev_oe(dev_oe), .dev_din(dev_din)
    );

    // Access requests issued from the current sequencer state.
    always_comb begin
        acc_start = 1'b0;
        acc_wr    = 1'b0;
        acc_addr  = OFS_STAT;
        acc_wdata = 8'h00;
        case (st)
            Q_POLL:   acc_start = !tmo_hit;
            Q_ERR_RD: begin acc_start = 1'b1; acc_addr = OFS_ERR; end
            Q_TF:     begin acc_start = 1'b1; acc_wr = 1'b1; acc_addr = tf_addr; acc_wdata = tf_data; end
            Q_DATA:   begin
                acc_start = !cur_write || wr_valid;
                acc_wr    = cur_write;
                acc_addr  = OFS_DATA;
                acc_wdata = wr_data;
            end
            default:  ;
        endcase
    end

    // User-side outputs.
    always_comb begin
        req_ready = (st == Q_IDLE);
        wr_ready  = (st == Q_DATA) && cur_write;
        rd_valid  = (st == Q_DATA_W) && acc_ack && !cur_write;
        rd_data   = acc_rdata;
        done      = (st == Q_FIN);
        err_dev   = err_dev_q;
        err_tmo   = err_tmo_q;
        err_code  = err_code_q;
        dev_rst_n = (st != Q_RST);
    end

    // Main sequence: reset, start-up wait, polls, task file, data, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= Q_RST;  wcnt <= '0;  tmo_cnt <= '0;  idx <= '0;  bcnt <= '0;
            in_init <= 1'b0;  drq_stage <= 1'b0;
            cur_write <= 1'b0;  cur_slave <= 1'b0;  cur_lba <= '0;  cur_count <= '0;
            err_dev_q <= 1'b0;  err_tmo_q <= 1'b0;  err_code_q <= '0;
        end else begin
            case (st)
                Q_RST: if (wcnt == WW'(RESET_CYC - 1)) begin
                    wcnt <= '0;  st <= Q_WAIT;
                end else wcnt <= wcnt + 1'b1;
                Q_WAIT: if (wcnt == WW'(STARTUP_CYC - 1)) begin
                    st <= Q_POLL;  in_init <= 1'b1;  drq_stage <= 1'b0;  tmo_cnt <= '0;
                end else wcnt <= wcnt + 1'b1;
                Q_IDLE: if (req_valid) begin
                    cur_write <= req_write;  cur_lba <= req_lba;
                    cur_count <= req_count;  cur_slave <= req_slave;
                    in_init <= 1'b0;  drq_stage <= 1'b0;  tmo_cnt <= '0;
                    err_dev_q <= 1'b0;  err_tmo_q <= 1'b0;  err_code_q <= '0;
                    st <= Q_POLL;
                end
                Q_POLL: begin
                    tmo_cnt <= tmo_cnt + 1'b1;
                    if (tmo_hit) begin err_tmo_q <= 1'b1;  st <= Q_FIN; end
                    else st <= Q_POLL_W;
                end
                Q_POLL_W: begin
                    tmo_cnt <= tmo_cnt + 1'b1;
                    if (acc_ack) begin
                        if (acc_rdata[BIT_BSY])                        st <= Q_POLL;
                        else if (acc_rdata[BIT_ERR])                   st <= Q_ERR_RD;
                        else if (drq_stage && !acc_rdata[BIT_DRQ])     st <= Q_POLL;
                        else if (drq_stage) begin bcnt <= '0;  st <= Q_DATA; end
                        else begin idx <= '0;  st <= Q_TF; end
                    end
                end
                Q_ERR_RD: st <= Q_ERR_W;
                Q_ERR_W: if (acc_ack) begin
                    err_code_q <= acc_rdata;  err_dev_q <= 1'b1;  st <= Q_FIN;
                end
                Q_TF: st <= Q_TF_W;
                Q_TF_W: if (acc_ack) begin
                    if (!tf_last) begin idx <= idx + 1'b1;  st <= Q_TF; end
                    else if (in_init) st <= Q_FIN;
                    else begin drq_stage <= 1'b1;  tmo_cnt <= '0;  st <= Q_POLL; end
                end
                Q_DATA: if (acc_start) st <= Q_DATA_W;
                Q_DATA_W: if (acc_ack) begin
                    if (bcnt == BW'(SECTOR_BYTES - 1)) st <= Q_FIN;
                    else begin bcnt <= bcnt + 1'b1;  st <= Q_DATA; end
                end
                default: st <= Q_IDLE;
            endcase
        end
    end

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R1
    no_bus_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_rst_n |-> dev_cs_n);
    // R9
    wr_take_starts_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> !dev_cs_n && dev_oe);
    // R6
    single_err_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(err_dev && err_tmo));
    // R11
    ready_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/ata_sector_seq_tb.sv
// Bench: behavioural device model on the register bus, per-access timing
// measurement, and per-sequence comparison of logged bus traffic against
// sequences computed from the requirements.
module ata_sector_seq_tb_top;
    localparam int P_SETUP = 2, P_STROBE = 3, P_HOLD = 1;
    localparam int P_RST = 4, P_START = 20, P_TMO = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic        req_valid = 1'b0, req_write = 1'b0, req_slave = 1'b0;
    logic [27:0] req_lba = '0;
    logic [7:0]  req_count = '0;
    logic        req_ready, wr_ready, rd_valid, done, err_dev, err_tmo;
    logic [7:0]  wr_data, rd_data, err_code, dev_dout;
    logic        wr_valid;
    logic [2:0]  dev_addr;
    logic        dev_cs_n, dev_rd_n, dev_wr_n, dev_oe, dev_rst_n;
    logic [7:0]  dev_din;

    ata_sector_seq #(
        .SETUP_CYC(P_SETUP), .STROBE_CYC(P_STROBE), .HOLD_CYC(P_HOLD),
        .RESET_CYC(P_RST), .STARTUP_CYC(P_START), .POLL_TIMEOUT(P_TMO)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_lba(req_lba), .req_count(req_count),
        .req_slave(req_slave), .wr_data(wr_data), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid), .done(done),
        .err_dev(err_dev), .err_tmo(err_tmo), .err_code(err_code),
        .dev_addr(dev_addr), .dev_cs_n(dev_cs_n), .dev_rd_n(dev_rd_n),
        .dev_wr_n(dev_wr_n), .dev_dout(dev_dout), .dev_oe(dev_oe),
        .dev_din(dev_din), .dev_rst_n(dev_rst_n)
    );

    int checks = 0, fails = 0;     // main process
    int mchecks = 0, mfails = 0;   // device model

    // Device configuration, written only by the main process.
    int   cfg_gen = 0, cfg_bsy_pre = 0, cfg_bsy_cmd = 0;
    bit   cfg_err_pre = 0, cfg_err_cmd = 0, cfg_stuck = 0;
    logic [7:0] cfg_err_val = 8'h00;

    // Device model state.
    int   seen_gen = 0, bsy_left = 0, rd_idx = 0, wr_idx = 0;
    bit   err_on = 0, drq_on = 0, in_acc = 0, acc_wr = 0;
    int   n_set = 0, n_stb = 0, n_hld = 0, ph = 0;
    logic [2:0]  acc_addr = '0;
    logic [7:0]  acc_data = '0;
    logic [7:0]  mem [512];
    logic [11:0] log_q [$];

    // Register-bus device model and access timing measurement.
    always @(negedge clk) begin
        if (seen_gen != cfg_gen) begin
            seen_gen = cfg_gen;  bsy_left = cfg_bsy_pre;  err_on = cfg_err_pre;  drq_on = 0;
        end
        if (!dev_cs_n) begin
            if (!in_acc) begin
                in_acc = 1;  ph = 0;  n_set = 0;  n_stb = 0;  n_hld = 0;
                acc_addr = dev_addr;  acc_wr = 0;
            end
            if (dev_addr != acc_addr || (!dev_rd_n && !dev_wr_n)) begin
                mfails++;  mchecks++;
                $display("FAIL R10: address moved or both strobes low, addr %0d exp %0d", dev_addr, acc_addr);
            end
            if (!dev_rd_n || !dev_wr_n) begin
                if (ph == 0 && !dev_rd_n) begin
                    if (dev_addr == 3'd7) begin
                        if (cfg_stuck) dev_din = 8'h80;
                        else if (bsy_left > 0) begin bsy_left--;  dev_din = 8'h80; end
                        else if (err_on) dev_din = 8'h41;
                        else if (drq_on) dev_din = 8'h58;
                        else dev_din = 8'h50;
                    end else if (dev_addr == 3'd1) dev_din = cfg_err_val;
                    else if (dev_addr == 3'd0) begin
                        dev_din = mem[rd_idx % 512];  rd_idx++;
                        if (rd_idx == 512) drq_on = 0;
                    end else dev_din = 8'h00;
                end
                ph = 1;  n_stb++;
                if (!dev_wr_n) begin acc_wr = 1;  acc_data = dev_dout; end
                else acc_data = dev_din;
            end else if (ph == 0) n_set++;
            else begin ph = 2;  n_hld++; end
            if (dev_oe != acc_wr && ph == 1) begin
                mfails++;  mchecks++;
                $display("FAIL R10: dev_oe %0d during access with write %0d", dev_oe, acc_wr);
            end
        end else if (in_acc) begin
            in_acc = 0;
            mchecks++;
            if (n_set != P_SETUP || n_stb != P_STROBE || n_hld != P_HOLD) begin
                mfails++;
                $display("FAIL R10: setup/strobe/hold %0d/%0d/%0d exp %0d/%0d/%0d",
                         n_set, n_stb, n_hld, P_SETUP, P_STROBE, P_HOLD);
            end
            log_q.push_back({acc_wr, acc_addr, acc_data});
            if (acc_wr && acc_addr == 3'd7 && (acc_data == 8'h20 || acc_data == 8'h30)) begin
                bsy_left = cfg_bsy_cmd;  rd_idx = 0;  wr_idx = 0;
                if (cfg_err_cmd) err_on = 1; else drq_on = 1;
            end else if (acc_wr && acc_addr == 3'd0) begin
                mem[wr_idx % 512] = acc_data;  wr_idx++;
                if (wr_idx == 512) drq_on = 0;
            end
        end
    end

    // Reset-phase timing monitor.
    int cyc = 0, rstlow = 0, first_cs = -1;
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (!dev_rst_n) rstlow++;
            if (!dev_cs_n && first_cs < 0) first_cs = cyc;
        end
    end

    // Read stream collector.
    logic [7:0] rd_q [$];
    always @(negedge clk) if (rd_valid) rd_q.push_back(rd_data);

    // Write stream source.
    bit   wr_en = 0, wr_pend = 0;
    int   wr_ptr = 0;
    logic [7:0] src [512];
    always @(negedge clk) begin
        if (!wr_en) begin
            wr_ptr = 0;  wr_pend = 0;  wr_valid = 1'b0;  wr_data = 8'h00;
        end else begin
            if (wr_pend) begin wr_ptr++;  wr_pend = 0; end
            wr_valid = (wr_ptr < 512) && (wr_ptr % 37 != 5 || (cyc % 2 == 0));
            wr_data  = src[wr_ptr % 512];
            if (wr_valid && wr_ready) wr_pend = 1;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", (checks + mchecks) - (fails + mfails), checks + mchecks);
        $finish;
    endtask

    bit got_dev, got_tmo;
    logic [7:0] got_code;
    int elapsed;

    task automatic wait_done();
        int k = 0;
        while (!done) begin
            @(negedge clk);
            k++;
            if (k > 20000) begin
                chk(0, "watchdog", k, 20000);
                finish_run();
            end
        end
        elapsed = k;
        got_dev = err_dev;  got_tmo = err_tmo;  got_code = err_code;
        @(negedge clk);
        chk(done == 1'b0, "R11 done one cycle", done, 0);
    endtask

    // Traffic summary of one sequence.
    int n_pre, n_post, n_data, n_errrd;
    logic [11:0] tf_seen [$];
    task automatic scan(input int base);
        bit seen_wr = 0, seen_cmd = 0;
        n_pre = 0;  n_post = 0;  n_data = 0;  n_errrd = 0;
        tf_seen.delete();
        for (int i = base; i < log_q.size(); i++) begin
            logic [11:0] e = log_q[i];
            if (e[10:8] == 3'd0) n_data++;
            else if (e[11]) begin
                tf_seen.push_back(e);  seen_wr = 1;
                if (e[10:8] == 3'd7) seen_cmd = 1;
            end else if (e[10:8] == 3'd7) begin
                if (!seen_wr) n_pre++;
                else if (seen_cmd && n_data == 0) n_post++;
            end else if (e[10:8] == 3'd1) n_errrd++;
        end
    endtask

    task automatic cmp_tf(input logic [11:0] exp [$], input string req);
        bit ok = (exp.size() == tf_seen.size());
        int bad = 0;
        for (int i = 0; i < exp.size() && ok; i++) if (tf_seen[i] != exp[i]) begin ok = 0; bad = i; end
        if (exp.size() != tf_seen.size()) chk(0, req, tf_seen.size(), exp.size());
        else chk(ok, req, ok ? 0 : tf_seen[bad], ok ? 0 : exp[bad]);
    endtask

    task automatic run_cmd(input bit w, input logic [27:0] lba, input logic [7:0] cnt, input bit slv);
        int k = 0;
        wr_en = w;
        while (!req_ready) begin @(negedge clk); k++; if (k > 20000) begin chk(0, "watchdog", k, 0); finish_run(); end end
        req_write = w;  req_lba = lba;  req_count = cnt;  req_slave = slv;  req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R11 ready drops", req_ready, 0);
        wait_done();
        wr_en = 0;
    endtask

    function automatic logic [11:0] ent(input logic [2:0] a, input logic [7:0] d);
        return {1'b1, a, d};
    endfunction

    function automatic void exp_cmd(ref logic [11:0] q [$], input bit w,
                                    input logic [27:0] lba, input logic [7:0] cnt, input bit slv);
        q.delete();
        q.push_back(ent(3'd2, cnt));
        q.push_back(ent(3'd3, lba[7:0]));
        q.push_back(ent(3'd4, lba[15:8]));
        q.push_back(ent(3'd5, lba[23:16]));
        q.push_back(ent(3'd6, {3'b111, slv, lba[27:24]}));
        q.push_back(ent(3'd7, w ? 8'h30 : 8'h20));
    endfunction

    initial begin
        logic [11:0] exp_q [$];
        int base, rbase;
        logic [27:0] lba_a = 28'h5A3C10A;

        for (int i = 0; i < 512; i++) src[i] = 8'((i * 7 + 3) ^ (i >> 3));
        cfg_bsy_pre = 3;  cfg_gen = 1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(dev_rst_n == 1'b0, "R1 dev_rst_n low in reset", dev_rst_n, 0);
        chk(dev_cs_n == 1'b1 && done == 1'b0 && req_ready == 1'b0, "R1 quiet in reset",
            {dev_cs_n, done, req_ready}, 3'b100);
        rst_n = 1'b1;

        // R2 start-up sequence
        wait_done();
        chk(rstlow >= P_RST && rstlow <= P_RST + 1, "R1 reset pulse length", rstlow, P_RST);
        chk(first_cs >= P_RST + P_START, "R1 first access after start-up", first_cs, P_RST + P_START);
        chk(!got_dev && !got_tmo, "R2 start-up no error", {got_dev, got_tmo}, 0);
        scan(0);
        chk(n_pre == 4, "R2 busy polls before 8-bit setup", n_pre, 4);
        exp_q.delete();
        exp_q.push_back(ent(3'd1, 8'h01));
        exp_q.push_back(ent(3'd6, 8'hE0));
        exp_q.push_back(ent(3'd7, 8'hEF));
        cmp_tf(exp_q, "R2 8-bit setup writes");
        chk(req_ready == 1'b1, "R2 ready after start-up", req_ready, 1);

        // R3/R4/R5/R9 write sector
        cfg_bsy_pre = 2;  cfg_bsy_cmd = 2;  cfg_gen++;
        base = log_q.size();
        run_cmd(1'b1, lba_a, 8'h01, 1'b0);
        scan(base);
        chk(!got_dev && !got_tmo, "R9 write no error", {got_dev, got_tmo}, 0);
        exp_cmd(exp_q, 1'b1, lba_a, 8'h01, 1'b0);
        cmp_tf(exp_q, "R3 write task file");
        chk(n_pre == 3, "R4 busy polls before task file", n_pre, 3);
        chk(n_post == 3, "R5 polls before data phase", n_post, 3);
        chk(n_data == 512, "R9 data writes", n_data, 512);
        begin
            int bad = -1;
            for (int i = 0; i < 512; i++) if (mem[i] !== src[i] && bad < 0) bad = i;
            chk(bad < 0, "R9 written bytes in order", bad < 0 ? 0 : mem[bad], bad < 0 ? 0 : src[bad]);
        end

        // R3/R5/R8 read sector, slave select
        cfg_bsy_pre = 0;  cfg_bsy_cmd = 5;  cfg_gen++;
        base = log_q.size();  rbase = rd_q.size();
        run_cmd(1'b0, 28'hF00FF0E, 8'h07, 1'b1);
        scan(base);
        exp_cmd(exp_q, 1'b0, 28'hF00FF0E, 8'h07, 1'b1);
        cmp_tf(exp_q, "R3 read task file with slave");
        chk(n_pre == 1, "R4 single idle poll", n_pre, 1);
        chk(n_post == 6, "R5 polls until data request", n_post, 6);
        chk(n_data == 512, "R8 data reads", n_data, 512);
        chk(rd_q.size() - rbase == 512, "R8 rd_valid count", rd_q.size() - rbase, 512);
        begin
            int bad = -1;
            for (int i = 0; i < 512 && rbase + i < rd_q.size(); i++)
                if (rd_q[rbase + i] !== src[i] && bad < 0) bad = i;
            chk(bad < 0, "R8 read bytes in order", bad < 0 ? 0 : rd_q[rbase + bad], bad < 0 ? 0 : src[bad]);
        end

        // R6 device error before the command
        cfg_bsy_pre = 1;  cfg_err_pre = 1;  cfg_err_val = 8'h04;  cfg_gen++;
        base = log_q.size();
        run_cmd(1'b0, lba_a, 8'h01, 1'b0);
        scan(base);
        chk(got_dev && !got_tmo && got_code == 8'h04, "R6 pre-command error",
            {got_dev, got_tmo, got_code}, {2'b10, 8'h04});
        chk(tf_seen.size() == 0 && n_data == 0 && n_errrd == 1, "R6 no task file after error",
            {tf_seen.size(), n_data, n_errrd}, 1);
        cfg_err_pre = 0;

        // R6 device error after the command
        cfg_bsy_pre = 0;  cfg_bsy_cmd = 1;  cfg_err_cmd = 1;  cfg_err_val = 8'h10;  cfg_gen++;
        base = log_q.size();
        run_cmd(1'b1, lba_a, 8'h01, 1'b0);
        scan(base);
        chk(got_dev && !got_tmo && got_code == 8'h10, "R6 post-command error",
            {got_dev, got_tmo, got_code}, {2'b10, 8'h10});
        chk(n_data == 0 && n_errrd == 1 && tf_seen.size() == 6, "R6 no data after error",
            {n_data, n_errrd}, 1);
        cfg_err_cmd = 0;

        // R7 poll timeout on a device stuck busy
        cfg_stuck = 1;  cfg_gen++;
        base = log_q.size();
        run_cmd(1'b0, lba_a, 8'h01, 1'b0);
        scan(base);
        chk(got_tmo && !got_dev, "R7 timeout flag", {got_tmo, got_dev}, 2'b10);
        chk(elapsed >= P_TMO, "R7 timeout not early", elapsed, P_TMO);
        chk(tf_seen.size() == 0 && n_pre > 10, "R7 only status polls", tf_seen.size(), 0);
        cfg_stuck = 0;  cfg_gen++;

        // R8 recovery read after the timeout
        base = log_q.size();  rbase = rd_q.size();
        run_cmd(1'b0, lba_a, 8'h01, 1'b0);
        chk(!err_dev && !err_tmo, "R7 flags clear on next request", {err_dev, err_tmo}, 0);
        chk(rd_q.size() - rbase == 512, "R8 read after recovery", rd_q.size() - rbase, 512);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule